// File: doc/BRIEF.md
# Logarithmic-Depth Prefix Adder

This block is a purely combinational binary adder. It takes two unsigned operands of `WIDTH` bits and a carry input, and returns a `WIDTH`-bit sum and a carry output. `WIDTH` is a power of two, at least 4, with a default of 16. All carries come from a sparse binary prefix network built from one associative cell. The cell merges the generate/propagate pair of a more significant span with the pair of the adjacent less significant span.

The network has two parts. An upward reduction first merges neighbouring bits, then neighbouring pairs, and so on, doubling the span at each level until one span covers the whole word. A downward fill pass then merges the prefixes already known with the partial spans that are still open, so that every bit position ends up with a prefix reaching down to bit 0. The last reduction level and the first fill level depend only on results of the level before them, so they share one level. The network therefore has 2·log2(WIDTH) − 2 levels, which is six at the default width. The carry input is folded into the generate term of bit 0 before the network starts, so it needs no level of its own. Each sum bit is then one XOR of the bit propagate with the carry into that bit.

The block holds no state, has no clock, and its outputs settle in the same cycle as its inputs change. It is meant for address and datapath arithmetic where a ripple chain is too deep.

Top module: `bk_adder`

## Requirements
- R1: For every operand pair and carry input, the value {carry_out, sum_out} equals opnd_a + opnd_b + carry_in as unsigned integers (carry_out is bit WIDTH of the true total).
- R2: When opnd_a XOR opnd_b is all ones (every bit propagates), the carry input travels the whole word: carry_in = 1 gives sum_out = 0 and carry_out = 1, and carry_in = 0 gives sum_out all ones and carry_out = 0.
- R3: When bit i of both operands is 1 (a generate at bit i, i < WIDTH-1), the carry into bit i+1 is 1, so sum_out[i+1] = NOT (opnd_a[i+1] XOR opnd_b[i+1]).
- R4: When bit i of both operands is 0 (a kill at bit i, i < WIDTH-1), the carry into bit i+1 is 0, so sum_out[i+1] = opnd_a[i+1] XOR opnd_b[i+1].
- R5: Adding opnd_b = 0 with carry_in = 0 returns sum_out = opnd_a and carry_out = 0.
- R6: The operands are interchangeable: swapping opnd_a and opnd_b leaves sum_out and carry_out unchanged.
- R7: The extreme input opnd_a = opnd_b = all ones with carry_in = 1 gives sum_out all ones and carry_out = 1, and all-zero inputs give all-zero outputs.
- R8: The outputs are a combinational function of the current inputs: they are valid within the same clock cycle as an input change, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First unsigned operand |
| opnd_b | input | WIDTH | Second unsigned operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Low WIDTH bits of the total |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
Every result of this block is due zero cycles after its stimulus, because no register lies between the operand ports and the sum or carry outputs. The bench applies each input set just after a falling clock edge and samples the outputs a fixed 2 ns later. That is well before the next rising edge and after the combinational network has settled, so no check depends on the order of events at an edge. A 4-bit instance is checked exhaustively against a bench-side wide addition. The 16-bit instance is driven with directed full-carry-chain, generate and kill patterns, followed by seeded random operands.

// File: rtl/bk_pkg.sv
package bk_pkg;

    // generate / propagate pair of one span
    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Distance to the less significant partner of node (lv, idx) in the
    // prefix network of 2**lg bits; 0 means the node passes through.
    // Levels 1..lg-1 reduce, level lg reduces the top node and starts the
    // fill, levels lg+1..2*lg-2 finish the fill.
    function automatic int unsigned bk_link(input int unsigned lv,
                                            input int unsigned idx,
                                            input int unsigned lg);
        int unsigned span;
        int unsigned half;
        bk_link = 0;
        if (lv >= 1 && lv <= lg) begin
            span = 1 << lv;
            if (((idx + 1) % span) == 0)
                bk_link = 1 << (lv - 1);
        end
        if (lv >= lg && lv + 1 < 2 * lg) begin
            span = 1 << (2 * lg - 1 - lv);
            half = span >> 1;
            if (half != 0 && ((idx + 1) % span) == half && idx >= span)
                bk_link = half;
        end
    endfunction

    function automatic int unsigned bk_depth(input int unsigned lg);
        bk_depth = 2 * lg - 2;
    endfunction

endpackage

// File: rtl/bk_gp_gen.sv
module bk_gp_gen
    import bk_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_v,
    input  logic [WIDTH-1:0] b_v,
    input  logic             c_in,
    output gp_t  [WIDTH-1:0] leaf,
    output logic [WIDTH-1:0] prop
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign prop[i] = a_v[i] ^ b_v[i];
        if (i == 0) begin : g_lsb
            // carry input acts as the generate of a virtual bit below bit 0
            assign leaf[i].g = (a_v[i] & b_v[i]) | (prop[i] & c_in);
        end else begin : g_rest
            assign leaf[i].g = a_v[i] & b_v[i];
        end
        assign leaf[i].p = prop[i];
    end

endmodule

// File: rtl/bk_combine.sv
module bk_combine
    import bk_pkg::*;
(
    input  gp_t hi,
    input  gp_t lo,
    output gp_t y
);

    assign y.g = hi.g | (hi.p & lo.g);
    assign y.p = hi.p & lo.p;

endmodule

// File: rtl/bk_prefix_tree.sv
module bk_prefix_tree
    import bk_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  gp_t [WIDTH-1:0] leaf,
    output gp_t [WIDTH-1:0] pref
);

    localparam int unsigned LG   = $clog2(WIDTH);
    localparam int unsigned LVLS = bk_depth(LG);

    gp_t [WIDTH-1:0] node [0:LVLS];

    assign node[0] = leaf;

    for (genvar lv = 1; lv <= LVLS; lv++) begin : g_lvl
        for (genvar i = 0; i < WIDTH; i++) begin : g_pos
            localparam int unsigned DIST = bk_link(lv, i, LG);
            if (DIST != 0) begin : g_cell
                bk_combine u_cell (
                    .hi (node[lv-1][i]),
                    .lo (node[lv-1][i-DIST]),
                    .y  (node[lv][i])
                );
            end else begin : g_wire
                assign node[lv][i] = node[lv-1][i];
            end
        end
    end

    assign pref = node[LVLS];

endmodule

// File: rtl/bk_sum_stage.sv
module bk_sum_stage #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] prop,
    input  logic [WIDTH-1:0] cvec,
    output logic [WIDTH-1:0] sum_v
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_sum
        assign sum_v[i] = prop[i] ^ cvec[i];
    end

endmodule

// File: rtl/bk_adder.sv
module bk_adder
    import bk_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);

    localparam int unsigned EXT = WIDTH + 1;

    gp_t  [WIDTH-1:0] leaf;
    gp_t  [WIDTH-1:0] pref;
    logic [WIDTH-1:0] prop;
    logic [WIDTH-1:0] cvec;

    bk_gp_gen #(.WIDTH(WIDTH)) u_gp (
        .a_v  (opnd_a),
        .b_v  (opnd_b),
        .c_in (carry_in),
        .leaf (leaf),
        .prop (prop)
    );

    bk_prefix_tree #(.WIDTH(WIDTH)) u_tree (
        .leaf (leaf),
        .pref (pref)
    );

    assign cvec[0] = carry_in;
    for (genvar i = 1; i < WIDTH; i++) begin : g_cv
        assign cvec[i] = pref[i-1].g;
    end

    bk_sum_stage #(.WIDTH(WIDTH)) u_sum (
        .prop  (prop),
        .cvec  (cvec),
        .sum_v (sum_out)
    );

    assign carry_out = pref[WIDTH-1].g;

    always_comb begin
        if (!$isunknown({opnd_a, opnd_b, carry_in})) begin
            // R1
            total_sum_chk: assert ({carry_out, sum_out} ==
                ({1'b0, opnd_a} + {1'b0, opnd_b} + EXT'(carry_in)))
                else $error("R1 total mismatch");
            // R2
            full_prop_chk: assert (!(&prop) ||
                (carry_out == carry_in && sum_out == {WIDTH{~carry_in}}))
                else $error("R2 full propagate mismatch");
            // R5
            identity_chk: assert (!(opnd_b == '0 && !carry_in) ||
                (sum_out == opnd_a && !carry_out))
                else $error("R5 identity mismatch");
            for (int i = 0; i < WIDTH - 1; i++) begin
                // R3
                gen_carry_chk: assert (!(opnd_a[i] && opnd_b[i]) || cvec[i+1])
                    else $error("R3 generate lost at bit %0d", i);
                // R4
                kill_carry_chk: assert ((opnd_a[i] || opnd_b[i]) || !cvec[i+1])
                    else $error("R4 kill leaked at bit %0d", i);
            end
            for (int i = 0; i < WIDTH; i++) begin
                // R2: a fully propagating prefix carries exactly the input carry
                prefix_pass_chk: assert (!pref[i].p || (pref[i].g == carry_in))
                    else $error("R2 prefix pass mismatch at %0d", i);
            end
        end
    end

endmodule

// File: tb/bk_adder_tb.sv
module bk_adder_tb_top;

    localparam int unsigned W  = 16;
    localparam int unsigned W4 = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [W-1:0]  a16, b16, s16;
    logic          ci16, co16;
    logic [W4-1:0] a4, b4, s4;
    logic          ci4, co4;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    bk_adder #(.WIDTH(W)) dut_i (
        .opnd_a (a16), .opnd_b (b16), .carry_in (ci16),
        .sum_out (s16), .carry_out (co16)
    );

    bk_adder #(.WIDTH(W4)) dut_w4_i (
        .opnd_a (a4), .opnd_b (b4), .carry_in (ci4),
        .sum_out (s4), .carry_out (co4)
    );

    function automatic logic [W:0] ref16(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic c);
        longint unsigned t;
        t = longint'(x) + longint'(y) + longint'(c);
        return t[W:0];
    endfunction

    function automatic logic [W4:0] ref4(input int x, input int y, input int c);
        int t;
        t = x + y + c;
        return t[W4:0];
    endfunction

    task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // drive after falling edge, sample 2 ns later (R8: same-cycle result)
    task automatic drive16(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
        @(negedge clk);
        a16 = x; b16 = y; ci16 = c;
        #2;
    endtask

    task automatic run16(input string req, input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic c);
        drive16(x, y, c);
        chk(req, {co16, s16}, ref16(x, y, c));
    endtask

    initial begin
        int unsigned cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !done) begin
                total++; bad++;
                $display("FAIL watchdog act=%0d exp<150000", cyc);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [W:0] first;
        a16 = '0; b16 = '0; ci16 = 1'b0;
        a4 = '0; b4 = '0; ci4 = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R7: all-zero start state
        drive16('0, '0, 1'b0);
        chk("R7 zero", {co16, s16}, '0);
        // R7: extreme all-ones with carry
        drive16('1, '1, 1'b1);
        chk("R7 max", {co16, s16}, {1'b1, {W{1'b1}}});
        // R2: full propagate chain, both carry values
        drive16(16'hA5A5, 16'h5A5A, 1'b1);
        chk("R2 chain cin1", {co16, s16}, {1'b1, {W{1'b0}}});
        drive16(16'hFFFF, 16'h0000, 1'b0);
        chk("R2 chain cin0", {co16, s16}, {1'b0, {W{1'b1}}});
        run16("R2 chain to top", 16'h7FFF, 16'h0001, 1'b0);
        run16("R1 top gen", 16'h8000, 16'h8000, 1'b0);
        // R3: generate at bit 3 into bit 4 (bits 4 both zero -> sum bit 4 = 1)
        drive16(16'h0008, 16'h0008, 1'b0);
        chk("R3 gen bit3", {16'b0, s16[4]}, {16'b0, 1'b1});
        run16("R3 gen mid", 16'h00F0, 16'h0010, 1'b0);
        // R4: kill at bit 7 stops chain: bit 8 sum = a8^b8
        drive16(16'h017F, 16'h0001, 1'b1);
        chk("R4 kill bit7", {16'b0, s16[8]}, {16'b0, 1'b1});
        run16("R4 kill", 16'hF0F0, 16'h0F00, 1'b1);
        // R5: identity
        drive16(16'h1234, 16'h0000, 1'b0);
        chk("R5 identity", {co16, s16}, {1'b0, 16'h1234});

        // R1/R6: seeded random with operand swap
        void'($urandom(32'h0BADC0DE));
        for (int k = 0; k < 1500; k++) begin
            logic [W-1:0] x, y;
            logic c;
            x = W'($urandom);
            y = W'($urandom);
            c = 1'($urandom);
            if (k % 5 == 0) y = ~x;
            run16("R1 random", x, y, c);
            first = {co16, s16};
            drive16(y, x, c);
            chk("R6 swap", {co16, s16}, first);
        end

        // R1: exhaustive 4-bit
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                for (int c = 0; c < 2; c++) begin
                    @(negedge clk);
                    a4 = W4'(x); b4 = W4'(y); ci4 = 1'(c);
                    #2;
                    chk("R1 exhaustive4", {12'b0, co4, s4}, {12'b0, ref4(x, y, c)});
                end
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule